// File: doc/BRIEF.md
# Downlink Command Frame Assembler

This block turns one reader-to-tag command for a low-frequency RFID downlink into an ordered serial bit stream. The stream is sent first bit first, and each multi-bit field goes out most significant bit first. The block takes five inputs: a control byte, a block selector, a 32-bit data word, a 32-bit password and a start pulse. In the cycle after an accepted start, it registers the whole frame, left-justified, together with its bit count, the downlink mode and a flag that marks an odd length in one-of-four mode.

A symbol transmitter drains the frame one bit at a time through a valid/ready handshake. It uses the reported mode to pick pulse timing, for example to emit a long reference pulse in mode 1. In one-of-four mode it uses the odd flag to detect a frame that cannot be split evenly into bit pairs.

The frame outputs stay unchanged from an accepted start until the transmitter takes the last bit. Start pulses that arrive during that time are ignored.

Top module: `dlf_assembler`

## Requirements
- R1: After synchronous reset, `tx_valid`, `tx_last` and `busy` are 0, and `frm_bits`, `frm_len`, `frm_mode` and `frm_odd` are 0.
- R2: The control byte is decoded as follows. Bit 0 enables the password. Bit 1 is the page. Bit 2 selects test mode. Bits 4:3 select the downlink mode: 0 fixed length, 1 long reference, 2 leading zero, 3 one-of-four. Bit 5 forces register-read. Bit 6 marks a read. Bit 7 is ignored. A read whose block selector equals 0xFF also forces register-read. Otherwise the address is the low 3 bits of the selector.
- R3: The frame opens with a reference prefix that depends on the mode. Mode 2 adds one 0 bit and mode 3 adds the pair 00. Modes 0 and 1 add nothing.
- R4: Two opcode bits follow the prefix. In normal operation they are 1 and then the page bit. In test mode they are 0 and then 1, whatever the page bit is.
- R5: With the password enabled, modes 2 and 3 insert two 0 bits after the opcode. In every mode the 32 password bits then follow, MSB first. With the password disabled, none of these bits appear.
- R6: Next comes a lock bit of 0. The 32 data bits follow, MSB first, unless the command is a read. The 3 address bits close the frame, MSB first, unless register-read is in force.
- R7: `frm_bits` holds the frame with the first bit at bit 79 and every unused low bit at 0. `frm_len` equals the number of frame bits, which is never more than 80.
- R8: One cycle after an accepted start, `tx_valid` rises with the first bit on `tx_bit`. The bit moves on only on a cycle with both valid and ready high. `tx_last` marks the final bit. `tx_valid` falls in the cycle after the final bit is taken.
- R9: `start` is ignored while `busy` is high. The frame outputs stay stable until the final bit has been taken.
- R10: `frm_odd` is 1 exactly when the mode is 3 and `frm_len` is odd.
- R11: `frm_mode` reports the downlink mode of the frame that is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that requests assembly of a new frame |
| ctrl | input | 8 | Command control byte |
| blk_sel | input | 8 | Block selector; 0xFF on a read means register-read |
| data_word | input | 32 | Data to write |
| passwd | input | 32 | Password |
| tx_ready | input | 1 | Transmitter accepts the current bit |
| tx_valid | output | 1 | A frame bit is offered |
| tx_bit | output | 1 | Current frame bit |
| tx_last | output | 1 | Current bit is the final bit of the frame |
| busy | output | 1 | A frame is held and not yet fully consumed |
| frm_bits | output | 80 | Held frame, left-justified |
| frm_len | output | 7 | Frame length in bits |
| frm_mode | output | 2 | Downlink mode of the held frame |
| frm_odd | output | 1 | Odd length in one-of-four mode |

## Verification
The bench sweeps all 256 control bytes with block selectors that alternate between 0xFF and other values. This covers the ambiguous cases: reference prefixes in each mode, test mode overriding the page bit, the extra zero pair that appears only with a password in modes 2 and 3, and 0xFF mattering only on reads. A design that mixed these up would emit frames of the wrong length, such as a 5-bit register-read frame with a stray address field, or a password missing its two leading zeros. The bench throttles `tx_ready` to catch a serializer that advances without a handshake or that drops valid one bit early or late. It also injects a start mid-frame to catch a design that reloads while busy and corrupts the frame being sent.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    DL_FIXED    = 2'd0,
    DL_LONGREF  = 2'd1,
    DL_LEADZERO = 2'd2,
    DL_ONEOF4   = 2'd3
  } dl_mode_e;

  typedef struct packed {
    logic     pwd_en;
    logic     page;
    logic     test;
    dl_mode_e mode;
    logic     reg_read;
    logic     read_cmd;
  } cmd_fields_t;
endpackage

// File: rtl/dlf_ctrl_decode.sv
module dlf_ctrl_decode
  import dlf_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [BLK_W-1:0]  blk_sel,
  output cmd_fields_t       fields,
  output logic [ADDR_W-1:0] addr
);
  logic sel_all_ones;

  always_comb begin
    sel_all_ones    = &blk_sel;
    fields.pwd_en   = ctrl[0];
    fields.page     = ctrl[1];
    fields.test     = ctrl[2];
    fields.mode     = dl_mode_e'(ctrl[4:3]);
    fields.read_cmd = ctrl[6];
    // R2: an all-ones selector on a read means register-read
    fields.reg_read = ctrl[5] | (ctrl[6] & sel_all_ones);
    addr            = blk_sel[ADDR_W-1:0];
  end
endmodule

// File: rtl/dlf_frame_build.sv
module dlf_frame_build
  import dlf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PWD_W    = 32,
  parameter int ADDR_W   = 3,
  parameter int MAX_BITS = 80,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  cmd_fields_t       fields,
  input  logic [DATA_W-1:0] data_word,
  input  logic [PWD_W-1:0]  passwd,
  input  logic [ADDR_W-1:0] addr,
  output logic [MAX_BITS-1:0] frame,
  output logic [CNT_W-1:0]    len,
  output logic                odd
);
  localparam logic [CNT_W-1:0] MAXB = CNT_W'(MAX_BITS);

  logic [MAX_BITS-1:0] acc;
  logic [CNT_W-1:0]    n;
  logic                zero_pad_mode;

  always_comb begin
    acc = '0;
    n   = '0;
    zero_pad_mode = (fields.mode == DL_LEADZERO) || (fields.mode == DL_ONEOF4);
    // R3 reference prefix
    if (zero_pad_mode) begin
      acc = acc << 1;
      n   = n + CNT_W'(1);
    end
    if (fields.mode == DL_ONEOF4) begin
      acc = acc << 1;
      n   = n + CNT_W'(1);
    end
    // R4 opcode
    acc = {acc[MAX_BITS-3:0], ~fields.test, fields.test | fields.page};
    n   = n + CNT_W'(2);
    // R5 optional password
    if (fields.pwd_en) begin
      if (zero_pad_mode) begin
        acc = acc << 2;
        n   = n + CNT_W'(2);
      end
      acc = {acc[MAX_BITS-PWD_W-1:0], passwd};
      n   = n + CNT_W'(PWD_W);
    end
    // R6 lock, data, address
    acc = acc << 1;
    n   = n + CNT_W'(1);
    if (!fields.read_cmd) begin
      acc = {acc[MAX_BITS-DATA_W-1:0], data_word};
      n   = n + CNT_W'(DATA_W);
    end
    if (!fields.reg_read) begin
      acc = {acc[MAX_BITS-ADDR_W-1:0], addr};
      n   = n + CNT_W'(ADDR_W);
    end
    // R7 left-justify so the first bit sits at the top
    frame = acc << (MAXB - n);
    len   = n;
    odd   = (fields.mode == DL_ONEOF4) && n[0];
  end
endmodule

// File: rtl/dlf_serializer.sv
module dlf_serializer #(
  parameter int MAX_BITS = 80,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_bits,
  input  logic [CNT_W-1:0]    load_len,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic                tx_bit,
  output logic                tx_last
);
  logic [MAX_BITS-1:0] sh_q;
  logic [CNT_W-1:0]    rem_q;
  logic                valid_q;
  logic                last_q;
  logic                take;

  assign take = valid_q & tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      rem_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (load && !valid_q) begin
      sh_q    <= load_bits;
      rem_q   <= load_len;
      valid_q <= (load_len != '0);
      last_q  <= (load_len == CNT_W'(1));
    end else if (take) begin
      sh_q    <= sh_q << 1;
      rem_q   <= rem_q - CNT_W'(1);
      valid_q <= (rem_q != CNT_W'(1));
      last_q  <= (rem_q == CNT_W'(2));
    end
  end

  assign tx_valid = valid_q;
  assign tx_bit   = sh_q[MAX_BITS-1];
  assign tx_last  = last_q;

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_bit) && $stable(tx_last))); // R8
  AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid); // R8
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid); // R8
endmodule

// File: rtl/dlf_assembler.sv
module dlf_assembler
  import dlf_pkg::*;
#(
  parameter int BLK_W    = 8,
  parameter int DATA_W   = 32,
  parameter int PWD_W    = 32,
  parameter int ADDR_W   = 3,
  parameter int MAX_BITS = 80,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CTRL_W-1:0]   ctrl,
  input  logic [BLK_W-1:0]    blk_sel,
  input  logic [DATA_W-1:0]   data_word,
  input  logic [PWD_W-1:0]    passwd,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic                tx_bit,
  output logic                tx_last,
  output logic                busy,
  output logic [MAX_BITS-1:0] frm_bits,
  output logic [CNT_W-1:0]    frm_len,
  output logic [1:0]          frm_mode,
  output logic                frm_odd
);
  cmd_fields_t         fields;
  logic [ADDR_W-1:0]   addr;
  logic [MAX_BITS-1:0] frame_c;
  logic [CNT_W-1:0]    len_c;
  logic                odd_c;
  logic                accept;

  logic [MAX_BITS-1:0] frm_bits_q;
  logic [CNT_W-1:0]    frm_len_q;
  logic [1:0]          frm_mode_q;
  logic                frm_odd_q;

  dlf_ctrl_decode #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_decode (
    .ctrl    (ctrl),
    .blk_sel (blk_sel),
    .fields  (fields),
    .addr    (addr)
  );

  dlf_frame_build #(
    .DATA_W(DATA_W), .PWD_W(PWD_W), .ADDR_W(ADDR_W),
    .MAX_BITS(MAX_BITS), .CNT_W(CNT_W)
  ) u_build (
    .fields    (fields),
    .data_word (data_word),
    .passwd    (passwd),
    .addr      (addr),
    .frame     (frame_c),
    .len       (len_c),
    .odd       (odd_c)
  );

  // R9 a start is only taken while idle
  assign accept = start & ~tx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_bits_q <= '0;
      frm_len_q  <= '0;
      frm_mode_q <= '0;
      frm_odd_q  <= 1'b0;
    end else if (accept) begin
      frm_bits_q <= frame_c;
      frm_len_q  <= len_c;
      frm_mode_q <= fields.mode;
      frm_odd_q  <= odd_c;
    end
  end

  dlf_serializer #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_bits (frame_c),
    .load_len  (len_c),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_bit    (tx_bit),
    .tx_last   (tx_last)
  );

  assign busy     = tx_valid;
  assign frm_bits = frm_bits_q;
  assign frm_len  = frm_len_q;
  assign frm_mode = frm_mode_q;
  assign frm_odd  = frm_odd_q;

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !(tx_ready && tx_last)) |=> ($stable(frm_bits) && $stable(frm_len) && $stable(frm_mode))); // R9
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    frm_len <= CNT_W'(MAX_BITS)); // R7
  AST_START_VALID: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && frm_len != '0)); // R8
  AST_ODD_PAIRS: assert property (@(posedge clk) disable iff (rst)
    (frm_odd) |-> (frm_mode == 2'd3)); // R10
endmodule

// File: tb/dlf_assembler_tb.sv
module dlf_assembler_tb;
  localparam int MAXB = 80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  ctrl = '0;
  logic [7:0]  blk_sel = '0;
  logic [31:0] data_word = '0;
  logic [31:0] passwd = '0;
  logic        tx_ready = 1'b0;
  logic        tx_valid, tx_bit, tx_last, busy, frm_odd;
  logic [79:0] frm_bits;
  logic [6:0]  frm_len;
  logic [1:0]  frm_mode;

  int checks = 0;
  int errors = 0;

  logic       ex [0:MAXB-1];
  int         en;
  logic [79:0] ev;

  always #4 clk = ~clk;

  dlf_assembler u_dut (
    .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .blk_sel(blk_sel),
    .data_word(data_word), .passwd(passwd), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_last(tx_last), .busy(busy),
    .frm_bits(frm_bits), .frm_len(frm_len), .frm_mode(frm_mode), .frm_odd(frm_odd)
  );

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic v);
    ex[en] = v;
    en++;
  endtask

  task automatic push_word(input logic [31:0] w, input int width);
    for (int k = width - 1; k >= 0; k--) push(w[k]);
  endtask

  task automatic build_exp(input logic [7:0] c, input logic [7:0] b,
                           input logic [31:0] d, input logic [31:0] p);
    logic [1:0] m;
    logic rr;
    en = 0;
    m  = c[4:3];
    rr = c[5] | (c[6] && b == 8'hFF);
    if (m >= 2) push(1'b0);
    if (m == 3) push(1'b0);
    if (c[2]) begin push(1'b0); push(1'b1); end
    else begin push(1'b1); push(c[1]); end
    if (c[0]) begin
      if (m >= 2) begin push(1'b0); push(1'b0); end
      push_word(p, 32);
    end
    push(1'b0);
    if (!c[6]) push_word(d, 32);
    if (!rr) push_word({29'd0, b[2:0]}, 3);
    ev = '0;
    for (int k = 0; k < en; k++) ev[MAXB-1-k] = ex[k];
  endtask

  task automatic run_frame(input logic [7:0] c, input logic [7:0] b,
                           input logic [31:0] d, input logic [31:0] p);
    int i;
    int guard;
    build_exp(c, b, d, p);
    @(negedge clk);
    ctrl = c; blk_sel = b; data_word = d; passwd = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", 80'(busy), 80'd1);
    check(frm_len == 7'(en), "R7 frame length", 80'(frm_len), 80'(en));
    check(frm_bits == ev, "R2 R3 R4 R5 R6 R7 frame layout", frm_bits, ev);
    check(frm_mode == c[4:3], "R11 mode report", 80'(frm_mode), 80'(c[4:3]));
    check(frm_odd == (c[4:3] == 2'd3 && en[0]), "R10 odd flag", 80'(frm_odd),
          80'(c[4:3] == 2'd3 && en[0]));
    i = 0;
    guard = 0;
    while (i < en && guard < 1000) begin
      tx_ready = ((i + c + guard) % 3) != 0;
      check(tx_valid == 1'b1, "R8 valid during frame", 80'(tx_valid), 80'd1);
      check(tx_bit == ex[i], "R8 serial bit order", 80'(tx_bit), 80'(ex[i]));
      check(tx_last == (i == en - 1), "R8 last marker", 80'(tx_last), 80'(i == en - 1));
      if (c[3:0] == 4'd0 && guard == 1) begin
        start = 1'b1;
        ctrl = ~c;
        blk_sel = ~b;
        data_word = ~d;
      end else start = 1'b0;
      @(negedge clk);
      guard++;
      if (tx_ready) i++;
    end
    tx_ready = 1'b0;
    start = 1'b0;
    check(tx_valid == 1'b0, "R8 valid drops after last", 80'(tx_valid), 80'd0);
    check(busy == 1'b0, "R8 idle after last", 80'(busy), 80'd0);
    check(frm_bits == ev && frm_len == 7'(en), "R9 frame held, start while busy ignored",
          frm_bits, ev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_valid == 0 && tx_last == 0 && busy == 0, "R1 reset handshake", 80'({tx_valid, tx_last, busy}), 80'd0);
    check(frm_bits == 0 && frm_len == 0 && frm_mode == 0 && frm_odd == 0, "R1 reset frame", frm_bits, 80'd0);
    for (int c = 0; c < 256; c++) begin
      logic [7:0]  b;
      logic [31:0] d;
      logic [31:0] p;
      b = (c % 4 == 0) ? 8'hFF : 8'(c * 29 + 3);
      d = 32'(32'h9E3779B9 * (c + 1));
      p = ~d ^ {8'(c), 24'h5A3C81};
      run_frame(8'(c), b, d, p);
    end
    run_frame(8'h40, 8'hFE, 32'h0, 32'h0);
    run_frame(8'h59, 8'hFF, 32'hFFFFFFFF, 32'h80000001);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule